// File: doc/BRIEF.md
# Four-Port Pin I/O Controller with Per-Pin Drive Configuration

This block drives and samples up to 29 general-purpose pins, grouped as four byte-wide ports, the last of which has only five pins. Software reaches it through two small write/read channels. A runtime register window, 16 bytes wide, holds the output-value byte of each port, the synchronised input byte of each port and, for the two lowest ports only, an event-enable byte and an event-status byte. A separate configuration channel first takes a pin-select code. That code packs a port number and a bit number into one byte. The channel then reads or writes a three-bit drive setting for the pin it names: driver enable, push-pull or open-drain, and pull-up.

The pad side is three registered vectors (value, output enable, pull-up enable) plus a single registered event line. In open-drain mode a pin pulls low for a 0 and lets go for a 1. Edge events on the two lower ports are latched per bit, cleared by writing ones, and gated by their enables onto the event line.

Top module: `gpio_unit`

## Requirements
- R1: A pin-select byte names port `sel[6:4]` and bit `sel[2:0]`, which is pin port*8+bit; `sel[7]` and `sel[3]` are ignored. A configuration write goes to the selected pin, and `cfg_rdata` returns that pin's setting one cycle after the selection or the setting changes.
- R2: A select code that names no existing pin (port 4 or above, or port 3 bit 5 or above) makes configuration writes have no effect, and `cfg_rdata` reads 0.
- R3: In a setting, bit 0 enables the driver, bit 1 selects push-pull (0 means open-drain) and bit 2 enables the pull-up. Bits 7:3 are not stored and read 0.
- R4: With the driver enabled in push-pull mode, `pad_oe`=1 and `pad_out` equals the output bit. With the driver enabled in open-drain mode, `pad_oe`=1 when the output bit is 0 and 0 when it is 1. With the driver disabled, `pad_oe`=0. `pad_out` is 0 in open-drain mode. `pad_pu` follows setting bit 2. The pad vectors change one cycle after the register that feeds them.
- R5: The output-value bytes of ports 0, 1, 2 and 3 sit at offsets 0x0, 0x4, 0x8 and 0xA, and each reads back the value written to it.
- R6: The input bytes of ports 0 to 3 sit at 0x1, 0x5, 0x9 and 0xB. They show `pad_in` after a two-flop synchroniser, so a pad change appears in a read started two cycles later.
- R7: Port 3 bits 7:5 read 0 in both its output and input bytes. Offsets 0xC to 0xF read 0, and writes to them have no effect.
- R8: Event enables sit at 0x2 for port 0 and 0x6 for port 1; event status sits at 0x3 and 0x7. A status bit sets on a 0-to-1 change of its synchronised input while its enable bit is 1. A level that is already high does not set it.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a clear and a new edge fall in the same cycle, the bit stays set.
- R10: `event_o` is the registered OR of every status bit whose enable bit is 1.
- R11: After reset every setting is 0, every output value is 0, every enable and status bit is 0, and all pad outputs and `event_o` are 0.
- R12: `rt_rdata` is registered. It shows the register at the offset presented one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rt_we | input | 1 | Runtime window write strobe |
| rt_addr | input | 4 | Runtime window offset (read and write) |
| rt_wdata | input | 8 | Runtime write data |
| rt_rdata | output | 8 | Runtime read data, one cycle after address |
| cfg_sel_we | input | 1 | Load pin-select code from `cfg_wdata` |
| cfg_we | input | 1 | Write setting of selected pin from `cfg_wdata` |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Setting of the selected pin |
| pad_in | input | NUM_PINS | Raw pad levels |
| pad_out | output | NUM_PINS | Pad drive value |
| pad_oe | output | NUM_PINS | Pad output enable |
| pad_pu | output | NUM_PINS | Pad pull-up enable |
| event_o | output | 1 | Enabled-event summary line |

## Verification
The status-clear write and the setting of a status bit by a fresh edge can fall in the same clock. The bench provokes this by raising a pad and then timing a one-to-clear write so that it lands on the exact edge where the synchronised rising edge is latched. It then reads the status byte and expects the bit to still be set. The enable byte and the event line also interact: a latched bit whose enable is later removed must drop `event_o` while the status byte still reads 1.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int PORT_W = 8;
  localparam int CFG_W  = 3;
  localparam int CFG_OE = 0;
  localparam int CFG_PP = 1;
  localparam int CFG_PU = 2;

  // runtime window map: ports 0/1 use a 4-byte stride, ports 2/3 a 2-byte stride
  function automatic logic [3:0] dout_ofs(input int p);
    return (p < 2) ? 4'(p * 4) : 4'(8 + (p - 2) * 2);
  endfunction

  function automatic logic [3:0] din_ofs(input int p);
    return dout_ofs(p) + 4'd1;
  endfunction

  function automatic logic [3:0] even_ofs(input int p);
    return 4'(p * 4 + 2);
  endfunction

  function automatic logic [3:0] evst_ofs(input int p);
    return 4'(p * 4 + 3);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk) begin
    s1_q <= d;
    s2_q <= s1_q;
  end

  assign q = s2_q;
endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 29
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sel_we,
  input  logic                cfg_we,
  input  logic [7:0]          wdata,
  output logic [7:0]          rdata,
  output logic [NUM_PINS-1:0] oe_en,
  output logic [NUM_PINS-1:0] pp_en,
  output logic [NUM_PINS-1:0] pu_en
);
  localparam int IDX_W = $clog2(NUM_PINS);

  logic [2:0] port_q, bit_q;
  logic [NUM_PINS-1:0][CFG_W-1:0] cfg_q;
  logic [5:0]       pin_code;
  logic [IDX_W-1:0] pin_idx;
  logic             sel_valid;

  assign pin_code  = {port_q, bit_q};
  assign pin_idx   = pin_code[IDX_W-1:0];
  assign sel_valid = (pin_code < 6'(NUM_PINS));

  always_ff @(posedge clk) begin
    if (rst) begin
      port_q <= '0;
      bit_q  <= '0;
      cfg_q  <= '0;
      rdata  <= '0;
    end else begin
      if (sel_we) begin
        port_q <= wdata[6:4];
        bit_q  <= wdata[2:0];
      end
      if (cfg_we && sel_valid) cfg_q[pin_idx] <= wdata[CFG_W-1:0];
      rdata <= sel_valid ? {{(8-CFG_W){1'b0}}, cfg_q[pin_idx]} : 8'h00;
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign oe_en[i] = cfg_q[i][CFG_OE];
    assign pp_en[i] = cfg_q[i][CFG_PP];
    assign pu_en[i] = cfg_q[i][CFG_PU];
  end

  // R2: a write through a select that names no pin leaves every setting alone
  p_badsel_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !sel_valid) |=> $stable(cfg_q));
endmodule

// File: rtl/gpio_evt_port.sv
module gpio_evt_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic         en_we,
  input  logic         st_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_q,
  output logic [W-1:0] st_q,
  output logic         pend
);
  logic [W-1:0] prev_q, set_v, clr_v;

  assign set_v = din & ~prev_q & en_q;
  assign clr_v = st_we ? wdata : '0;
  assign pend  = |(st_q & en_q);

  always_ff @(posedge clk) prev_q <= din;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
      st_q <= '0;
    end else begin
      if (en_we) en_q <= wdata;
      st_q <= (st_q & ~clr_v) | set_v;   // a fresh edge beats a clear
    end
  end

  // R8: an enabled rising edge is latched on the next clock
  p_edge_latched_r8: assert property (@(posedge clk) disable iff (rst)
    (|set_v) |=> ((st_q & $past(set_v)) == $past(set_v)));
  // R8: no status bit appears without an enabled edge
  p_no_spurious_r8: assert property (@(posedge clk) disable iff (rst)
    ((st_q & ~$past(st_q) & ~$past(set_v)) == '0));
  // R9: ones written to status clear bits that saw no edge
  p_w1c_r9: assert property (@(posedge clk) disable iff (rst)
    st_we |=> ((st_q & $past(wdata & ~set_v)) == '0));
endmodule

// File: rtl/gpio_unit.sv
module gpio_unit
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 29,
  parameter int EV_PORTS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rt_we,
  input  logic [3:0]          rt_addr,
  input  logic [7:0]          rt_wdata,
  output logic [7:0]          rt_rdata,
  input  logic                cfg_sel_we,
  input  logic                cfg_we,
  input  logic [7:0]          cfg_wdata,
  output logic [7:0]          cfg_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_pu,
  output logic                event_o
);
  localparam int NUM_PORTS = (NUM_PINS + PORT_W - 1) / PORT_W;
  localparam int PAD_BITS  = NUM_PORTS * PORT_W;
  localparam logic [PAD_BITS-1:0] IMPL = {PAD_BITS{1'b1}} >> (PAD_BITS - NUM_PINS);
  localparam logic [PORT_W-1:0]   TOP_MASK = IMPL[PAD_BITS-1 -: PORT_W];
  localparam logic [3:0]          LAST_DO  = dout_ofs(NUM_PORTS - 1);

  logic [NUM_PINS-1:0] din_s, oe_en, pp_en, pu_en, dout_pin;
  logic [PAD_BITS-1:0] din_x, dout_q;
  logic [EV_PORTS-1:0][PORT_W-1:0] ev_en, ev_st;
  logic [EV_PORTS-1:0] ev_pend;
  logic [7:0] rd_val;

  gpio_sync #(.W(NUM_PINS)) u_sync (.clk(clk), .d(pad_in), .q(din_s));

  assign din_x = PAD_BITS'(din_s);

  gpio_cfg_bank #(.NUM_PINS(NUM_PINS)) u_cfg (
    .clk(clk), .rst(rst), .sel_we(cfg_sel_we), .cfg_we(cfg_we),
    .wdata(cfg_wdata), .rdata(cfg_rdata),
    .oe_en(oe_en), .pp_en(pp_en), .pu_en(pu_en)
  );

  for (genvar e = 0; e < EV_PORTS; e++) begin : g_evt
    gpio_evt_port #(.W(PORT_W)) u_evt (
      .clk(clk), .rst(rst),
      .din(din_x[e*PORT_W +: PORT_W]),
      .en_we(rt_we && (rt_addr == even_ofs(e))),
      .st_we(rt_we && (rt_addr == evst_ofs(e))),
      .wdata(rt_wdata),
      .en_q(ev_en[e]), .st_q(ev_st[e]), .pend(ev_pend[e])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= '0;
    end else begin
      for (int p = 0; p < NUM_PORTS; p++)
        if (rt_we && (rt_addr == dout_ofs(p)))
          dout_q[p*PORT_W +: PORT_W] <= rt_wdata & IMPL[p*PORT_W +: PORT_W];
    end
  end

  always_comb begin
    rd_val = 8'h00;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (rt_addr == dout_ofs(p)) rd_val = dout_q[p*PORT_W +: PORT_W];
      if (rt_addr == din_ofs(p))  rd_val = din_x[p*PORT_W +: PORT_W];
    end
    for (int e = 0; e < EV_PORTS; e++) begin
      if (rt_addr == even_ofs(e)) rd_val = ev_en[e];
      if (rt_addr == evst_ofs(e)) rd_val = ev_st[e];
    end
  end

  assign dout_pin = dout_q[NUM_PINS-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rt_rdata <= '0;
      pad_out  <= '0;
      pad_oe   <= '0;
      pad_pu   <= '0;
      event_o  <= 1'b0;
    end else begin
      rt_rdata <= rd_val;
      pad_oe   <= oe_en & (pp_en | ~dout_pin);
      pad_out  <= pp_en & dout_pin;
      pad_pu   <= pu_en;
      event_o  <= |ev_pend;
    end
  end

  // R4: an open-drain pin never presents a high drive value
  p_od_no_high_r4: assert property (@(posedge clk) disable iff (rst)
    ((pad_out & ~$past(pp_en)) == '0));
  // R4: the driver turns on only for pins whose setting enables it
  p_oe_needs_cfg_r4: assert property (@(posedge clk) disable iff (rst)
    ((pad_oe & ~$past(oe_en)) == '0));
  // R6: the input image lags the pads by exactly two clocks
  p_sync_lag_r6: assert property (@(posedge clk) disable iff (rst)
    din_s == $past(pad_in, 2));
  // R7: absent bits of the last port read back as zero
  p_unimpl_zero_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(rt_addr) == LAST_DO) |-> ((rt_rdata & ~TOP_MASK) == 8'h00));
  // R10: the event line rises only from an enabled pending bit
  p_event_src_r10: assert property (@(posedge clk) disable iff (rst)
    event_o |-> $past(|ev_pend));
endmodule

// File: tb/gpio_unit_tb_top.sv
`timescale 1ns/1ps
module gpio_unit_tb_top;
  localparam int NP = 29;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rt_we = 1'b0, cfg_sel_we = 1'b0, cfg_we = 1'b0;
  logic [3:0] rt_addr = '0;
  logic [7:0] rt_wdata = '0, cfg_wdata = '0;
  logic [7:0] rt_rdata, cfg_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe, pad_pu;
  logic event_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  gpio_unit dut_i (
    .clk(clk), .rst(rst), .rt_we(rt_we), .rt_addr(rt_addr), .rt_wdata(rt_wdata),
    .rt_rdata(rt_rdata), .cfg_sel_we(cfg_sel_we), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .event_o(event_o)
  );

  typedef struct packed {
    logic [7:0] sel;
    logic [7:0] cfg;
    logic [7:0] dout;
    logic       oe;
    logic       out;
    logic       pu;
    logic [7:0] rb;
  } vec_t;

  localparam vec_t VECS [0:6] = '{
    '{8'h00, 8'h03, 8'h01, 1'b1, 1'b1, 1'b0, 8'h03},
    '{8'h15, 8'h01, 8'h00, 1'b1, 1'b0, 1'b0, 8'h01},
    '{8'h15, 8'h01, 8'h20, 1'b0, 1'b0, 1'b0, 8'h01},
    '{8'h27, 8'h04, 8'h80, 1'b0, 1'b0, 1'b1, 8'h04},
    '{8'h34, 8'h07, 8'h10, 1'b1, 1'b1, 1'b1, 8'h07},
    '{8'h32, 8'hFF, 8'h00, 1'b1, 1'b0, 1'b1, 8'h07},
    '{8'h8B, 8'h02, 8'h08, 1'b0, 1'b1, 1'b0, 8'h02}
  };

  function automatic logic [3:0] do_addr(input int p);
    case (p)
      0: return 4'h0;
      1: return 4'h4;
      2: return 4'h8;
      default: return 4'hA;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rt_write(input logic [3:0] a, input logic [7:0] d);
    rt_we = 1'b1; rt_addr = a; rt_wdata = d;
    @(negedge clk);
    rt_we = 1'b0;
  endtask

  task automatic rt_read(input logic [3:0] a, output logic [7:0] v);
    rt_addr = a;
    @(negedge clk);
    v = rt_rdata;
  endtask

  task automatic cfg_select(input logic [7:0] s);
    cfg_sel_we = 1'b1; cfg_wdata = s;
    @(negedge clk);
    cfg_sel_we = 1'b0;
  endtask

  task automatic cfg_write(input logic [7:0] c);
    cfg_we = 1'b1; cfg_wdata = c;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    logic [NP-1:0] oe_snap, pu_snap;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11: reset state
    check("R11 pad_oe", 32'(pad_oe), 32'h0);
    check("R11 pad_out", 32'(pad_out), 32'h0);
    check("R11 pad_pu", 32'(pad_pu), 32'h0);
    check("R11 event_o", 32'(event_o), 32'h0);
    check("R11 cfg_rdata", 32'(cfg_rdata), 32'h0);
    rt_read(4'h0, v); check("R11 dout0", 32'(v), 32'h0);

    // R1 R3 R4: table of pin settings and drive outcomes
    for (int i = 0; i < 7; i++) begin
      int port, pin;
      port = int'(VECS[i].sel[6:4]);
      pin  = port * 8 + int'(VECS[i].sel[2:0]);
      cfg_select(VECS[i].sel);
      cfg_write(VECS[i].cfg);
      rt_write(do_addr(port), VECS[i].dout);
      @(negedge clk);
      check("R1/R3 readback", 32'(cfg_rdata), 32'(VECS[i].rb));
      check("R4 pad_oe", 32'(pad_oe[pin]), 32'(VECS[i].oe));
      check("R4 pad_out", 32'(pad_out[pin]), 32'(VECS[i].out));
      check("R4 pad_pu", 32'(pad_pu[pin]), 32'(VECS[i].pu));
    end

    // R2: selects naming no pin
    oe_snap = pad_oe; pu_snap = pad_pu;
    cfg_select(8'h35); cfg_write(8'h07); @(negedge clk);
    check("R2 rb pin29", 32'(cfg_rdata), 32'h0);
    cfg_select(8'h45); cfg_write(8'h07); @(negedge clk);
    check("R2 rb port4", 32'(cfg_rdata), 32'h0);
    @(negedge clk);
    check("R2 pad_oe kept", 32'(pad_oe), 32'(oe_snap));
    check("R2 pad_pu kept", 32'(pad_pu), 32'(pu_snap));
    cfg_select(8'h05); @(negedge clk);
    check("R2 pin5 untouched", 32'(cfg_rdata), 32'h0);
    cfg_select(8'h34); @(negedge clk);
    check("R2 pin28 untouched", 32'(cfg_rdata), 32'h07);

    // R5 R7 R12: output bytes read back
    rt_write(4'h0, 8'h5A); rt_write(4'h4, 8'hC3);
    rt_write(4'h8, 8'h96); rt_write(4'hA, 8'hFF);
    rt_read(4'h0, v); check("R5 dout0", 32'(v), 32'h5A);
    rt_read(4'h4, v); check("R5 dout1", 32'(v), 32'hC3);
    rt_read(4'h8, v); check("R5 dout2", 32'(v), 32'h96);
    rt_read(4'hA, v); check("R7 dout3 masked", 32'(v), 32'h1F);
    rt_write(4'hC, 8'hFF);
    rt_read(4'hC, v); check("R7 hole 0xC", 32'(v), 32'h0);
    rt_read(4'hF, v); check("R7 hole 0xF", 32'(v), 32'h0);
    rt_read(4'h0, v); check("R7 hole write ignored", 32'(v), 32'h5A);

    // R6 R12: synchroniser and read latency
    rt_addr = 4'h1;
    @(negedge clk);
    pad_in[3:0] = 4'hA;
    @(negedge clk);
    @(negedge clk);
    check("R6 not yet visible", 32'(rt_rdata), 32'h0);
    @(negedge clk);
    check("R12 visible after sync+read", 32'(rt_rdata), 32'h0A);
    pad_in = 29'h1FA53C0F;
    repeat (3) @(negedge clk);
    rt_read(4'h1, v); check("R6 din0", 32'(v), 32'h0F);
    rt_read(4'h5, v); check("R6 din1", 32'(v), 32'h3C);
    rt_read(4'h9, v); check("R6 din2", 32'(v), 32'hA5);
    rt_read(4'hB, v); check("R7 din3", 32'(v), 32'h1F);

    // R8 R10: edge capture
    pad_in = '0;
    repeat (3) @(negedge clk);
    rt_write(4'h2, 8'h01);
    rt_write(4'h6, 8'h80);
    pad_in[0] = 1'b1; pad_in[1] = 1'b1; pad_in[15] = 1'b1;
    repeat (3) @(negedge clk);
    rt_read(4'h3, v); check("R8 st0 enabled only", 32'(v), 32'h01);
    rt_read(4'h7, v); check("R8 st1", 32'(v), 32'h80);
    check("R10 event high", 32'(event_o), 32'h1);

    // R9 R10: clear by writing ones
    rt_write(4'h3, 8'h01);
    rt_read(4'h3, v); check("R9 cleared", 32'(v), 32'h0);
    check("R10 port1 still pending", 32'(event_o), 32'h1);
    rt_write(4'h7, 8'h00);
    rt_read(4'h7, v); check("R9 zero write keeps", 32'(v), 32'h80);
    rt_write(4'h7, 8'h80);
    @(negedge clk);
    check("R10 event low", 32'(event_o), 32'h0);

    // R8: enabling a level already high sets nothing
    rt_write(4'h2, 8'h03);
    repeat (3) @(negedge clk);
    rt_read(4'h3, v); check("R8 level no set", 32'(v), 32'h0);

    // R10: enable gating of a latched bit
    pad_in[0] = 1'b0;
    repeat (3) @(negedge clk);
    pad_in[0] = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 event from bit0", 32'(event_o), 32'h1);
    rt_write(4'h2, 8'h00);
    @(negedge clk);
    check("R10 masked by enable", 32'(event_o), 32'h0);
    rt_read(4'h3, v); check("R10 status kept", 32'(v), 32'h01);

    // R9: clear and new edge in the same cycle
    rt_write(4'h2, 8'h01);
    rt_write(4'h3, 8'h01);
    pad_in[0] = 1'b0;
    repeat (3) @(negedge clk);
    rt_read(4'h3, v); check("R9 precondition clear", 32'(v), 32'h0);
    pad_in[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rt_write(4'h3, 8'h01);
    rt_read(4'h3, v); check("R9 set wins over clear", 32'(v), 32'h01);

    done = 1'b1;
    finish_run();
  end
endmodule